// File: doc/BRIEF.md
# Bit Rotation Packer Engine

This engine turns a swath of raster data into the column-ordered byte stream that a nozzle-column inkjet head consumes. Raster data sits in a two-bank rotation buffer: each bank holds one row per nozzle, and each row is a 16-bit word covering 16 horizontal pixel positions. The engine reads that buffer one bit per access. It collects the same pixel position from eight neighbouring nozzle rows and emits them as one byte, which rotates the image by 90 degrees.

A start pulse latches the configuration: the line length in bytes, the nozzle count, the column direction and the bit order within a byte. The engine then consumes the banks alternately. When a bank is used up it gives the bank back with a one-cycle pulse and waits until the other bank is reported full. It counts accepted bytes and signals the end of the swath. If the print side is ready for a byte while the engine is still waiting on an empty bank, it raises a sticky underrun flag. The engine only reads the buffer and never writes it. Filling the banks happens outside the block.

Top module: `brp_engine`

## Requirements
- R1: While reset is held and after its release, out_valid, mem_rd_en, busy, done, bank_done and underrun are 0.
- R2: With MSB-first packing, byte k of a column takes the selected bit from nozzle rows 8k to 8k+7. Row 8k lands in bit 7 and row 8k+7 in bit 0. The bytes of one column come out with k ascending, and mem_addr is {bank, row}.
- R3: With cfg_col_ascend = 0 the columns of a bank are taken from word bit 15 down to bit 0. With cfg_col_ascend = 1 they are taken from bit 0 up to bit 15.
- R4: With cfg_lsb_first = 1, row 8k lands in bit 0 and row 8k+7 in bit 7 of the output byte.
- R5: The first bank used is bank 0 and the banks alternate after that. No read is issued to a bank whose bank_full bit is 0. bank_done pulses once after each 2·NN bytes of a bank have been packed, and no read happens in that cycle, so a swath gives LL/2 pulses.
- R6: A swath delivers exactly LL·NN bytes, where LL is even and at least 2, and NN is a multiple of 8 between 8 and 64. done pulses in the cycle after the last accepted byte, with busy already 0.
- R7: underrun is set when the engine waits on an empty bank, holds no byte and out_ready is 1. It stays set until underrun_clr is 1 (a set condition in the same cycle wins), and out_valid is 0 while it is set. No byte is lost.
- R8: While out_valid is 1 and out_ready is 0, the next cycle still has out_valid at 1 and out_data unchanged.
- R9: A start pulse while busy is 1 is ignored: the running swath keeps its configuration and its byte stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a swath; latches configuration |
| cfg_line_len | input | 12 | Line length in bytes (even) |
| cfg_nozzles | input | 7 | Nozzle count (multiple of 8) |
| cfg_col_ascend | input | 1 | Column walk direction (1 = bit 0 upward) |
| cfg_lsb_first | input | 1 | First row read lands in bit 0 when 1 |
| bank_full | input | 2 | Per-bank "filled and ready" flags |
| mem_rd_en | output | 1 | Buffer read strobe |
| mem_addr | output | 7 | {bank, nozzle row} |
| mem_rd_data | input | 16 | Read data, one cycle after mem_rd_en |
| bank_done | output | 1 | Pulse: current bank consumed |
| out_valid | output | 1 | Packed byte available |
| out_ready | input | 1 | Print side accepts a byte |
| out_data | output | 8 | Packed byte |
| underrun | output | 1 | Sticky underrun flag |
| underrun_clr | input | 1 | Clears underrun |
| busy | output | 1 | Swath in progress |
| done | output | 1 | Pulse: swath complete |

## Verification
The hardest state to reach is an underrun that lasts while the missing bank is refilled. The flag must stay set and keep out_valid low even after data becomes available, and the stream must then resume with no byte lost. A directed swath holds bank 1 empty while out_ready is forced high. It fills the bank while the flag is still set, checks that nothing is delivered, and then clears the flag. Random swaths vary the refill delay and the ready duty cycle so that bank waits, back-pressure and automatic clears mix. A restart pulse in the middle of a swath exercises R9.

// File: rtl/brp_pkg.sv
package brp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_BANK,
    ST_WAIT_OUT,
    ST_READ,
    ST_DRAIN,
    ST_PUSH,
    ST_FLUSH
  } walk_state_e;

endpackage

// File: rtl/brp_walker.sv
module brp_walker
  import brp_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int BYTE_W  = 8,
  parameter int MAX_NOZ = 64,
  parameter int LL_W    = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [LL_W-1:0]              cfg_ll,
  input  logic [$clog2(MAX_NOZ):0]     cfg_nn,
  input  logic                         cfg_asc,
  input  logic                         cfg_lsb,
  input  logic [1:0]                   bank_full,
  input  logic                         out_full,
  input  logic                         swath_end,
  output logic                         load,
  output logic [LL_W-1:0]              ll_q,
  output logic [$clog2(MAX_NOZ):0]     nn_q,
  output logic                         rd_en,
  output logic [$clog2(MAX_NOZ):0]     rd_addr,
  output logic [$clog2(BYTE_W)-1:0]    rd_pos,
  output logic [$clog2(DATA_W)-1:0]    rd_col,
  output logic                         push,
  output logic                         bank_done,
  output logic                         wait_bank,
  output logic                         busy
);

  localparam int COL_W = $clog2(DATA_W);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam int ROW_W = $clog2(MAX_NOZ);
  localparam int NN_W  = ROW_W + 1;
  localparam int GRP_W = ROW_W - BIT_W;

  walk_state_e       state_q, state_d;
  logic              bank_q, bank_d;
  logic [COL_W-1:0]  col_q, col_d;
  logic [GRP_W-1:0]  grp_q, grp_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [LL_W-1:0]   chunk_q, chunk_d;
  logic [LL_W-1:0]   ll_d;
  logic [NN_W-1:0]   nn_d;
  logic              asc_q, asc_d, lsb_q, lsb_d;

  logic [GRP_W:0]    ngrp;
  logic              last_bit, last_grp, last_col, last_chunk;

  assign ngrp       = nn_q[NN_W-1:BIT_W];
  assign last_bit   = (bit_q == BIT_W'(BYTE_W - 1));
  assign last_grp   = ((GRP_W+1)'(grp_q) == ngrp - (GRP_W+1)'(1));
  assign last_col   = (col_q == COL_W'(DATA_W - 1));
  assign last_chunk = (chunk_q == (ll_q >> 1) - LL_W'(1));

  // next-state process
  always_comb begin
    state_d   = state_q;
    bank_d    = bank_q;
    col_d     = col_q;
    grp_d     = grp_q;
    bit_d     = bit_q;
    chunk_d   = chunk_q;
    ll_d      = ll_q;
    nn_d      = nn_q;
    asc_d     = asc_q;
    lsb_d     = lsb_q;
    load      = 1'b0;
    push      = 1'b0;
    bank_done = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          ll_d    = cfg_ll;
          nn_d    = cfg_nn;
          asc_d   = cfg_asc;
          lsb_d   = cfg_lsb;
          bank_d  = 1'b0;
          col_d   = '0;
          grp_d   = '0;
          bit_d   = '0;
          chunk_d = '0;
          state_d = ST_WAIT_BANK;
        end
      end
      ST_WAIT_BANK: begin
        if (bank_full[bank_q]) state_d = ST_WAIT_OUT;
      end
      ST_WAIT_OUT: begin
        if (!out_full) begin
          bit_d   = '0;
          state_d = ST_READ;
        end
      end
      ST_READ: begin
        if (last_bit) state_d = ST_DRAIN;
        else          bit_d   = bit_q + BIT_W'(1);
      end
      ST_DRAIN: state_d = ST_PUSH;
      ST_PUSH: begin
        push    = 1'b1;
        state_d = ST_WAIT_OUT;
        if (last_grp) begin
          grp_d = '0;
          if (last_col) begin
            col_d     = '0;
            bank_done = 1'b1;
            bank_d    = ~bank_q;
            chunk_d   = chunk_q + LL_W'(1);
            state_d   = last_chunk ? ST_FLUSH : ST_WAIT_BANK;
          end else begin
            col_d = col_q + COL_W'(1);
          end
        end else begin
          grp_d = grp_q + GRP_W'(1);
        end
      end
      ST_FLUSH: begin
        if (swath_end) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bank_q  <= 1'b0;
      col_q   <= '0;
      grp_q   <= '0;
      bit_q   <= '0;
      chunk_q <= '0;
      ll_q    <= '0;
      nn_q    <= '0;
      asc_q   <= 1'b0;
      lsb_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bank_q  <= bank_d;
      col_q   <= col_d;
      grp_q   <= grp_d;
      bit_q   <= bit_d;
      chunk_q <= chunk_d;
      if (load) begin
        ll_q  <= ll_d;
        nn_q  <= nn_d;
        asc_q <= asc_d;
        lsb_q <= lsb_d;
      end
    end
  end

  assign rd_en     = (state_q == ST_READ);
  assign rd_addr   = {bank_q, grp_q, bit_q};
  assign rd_pos    = lsb_q ? bit_q : (BIT_W'(BYTE_W - 1) - bit_q);
  assign rd_col    = asc_q ? col_q : (COL_W'(DATA_W - 1) - col_q);
  assign wait_bank = (state_q == ST_WAIT_BANK) && !bank_full[bank_q];
  assign busy      = (state_q != ST_IDLE);

endmodule

// File: rtl/brp_assembler.sv
module brp_assembler #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_en,
  input  logic [$clog2(BYTE_W)-1:0] rd_pos,
  input  logic [$clog2(DATA_W)-1:0] rd_col,
  input  logic [DATA_W-1:0]         rd_data,
  input  logic                      push,
  input  logic                      hold,
  input  logic                      out_ready,
  output logic                      out_valid,
  output logic [BYTE_W-1:0]         out_data,
  output logic                      out_full,
  output logic                      accept
);

  localparam int COL_W = $clog2(DATA_W);
  localparam int BIT_W = $clog2(BYTE_W);

  logic              tag_vld_q;
  logic [BIT_W-1:0]  tag_pos_q;
  logic [COL_W-1:0]  tag_col_q;
  logic [BYTE_W-1:0] acc_q, acc_d;
  logic [BYTE_W-1:0] out_q, out_d;
  logic              full_q, full_d;

  assign out_valid = full_q && !hold;
  assign accept    = out_valid && out_ready;
  assign out_full  = full_q;
  assign out_data  = out_q;

  // next-state process
  always_comb begin
    acc_d  = acc_q;
    out_d  = out_q;
    full_d = full_q;
    if (tag_vld_q) acc_d[tag_pos_q] = rd_data[tag_col_q];
    if (push) begin
      out_d  = acc_q;
      full_d = 1'b1;
    end else if (accept) begin
      full_d = 1'b0;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_vld_q <= 1'b0;
      tag_pos_q <= '0;
      tag_col_q <= '0;
      acc_q     <= '0;
      out_q     <= '0;
      full_q    <= 1'b0;
    end else begin
      tag_vld_q <= rd_en;
      if (rd_en) begin
        tag_pos_q <= rd_pos;
        tag_col_q <= rd_col;
      end
      acc_q  <= acc_d;
      out_q  <= out_d;
      full_q <= full_d;
    end
  end

endmodule

// File: rtl/brp_swath_ctl.sv
module brp_swath_ctl #(
  parameter int LL_W = 12,
  parameter int NN_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [LL_W-1:0] ll,
  input  logic [NN_W-1:0] nn,
  input  logic            accept,
  input  logic            wait_bank,
  input  logic            out_ready,
  input  logic            out_full,
  input  logic            underrun_clr,
  output logic            swath_end,
  output logic            done,
  output logic            underrun
);

  localparam int TOT_W = LL_W + NN_W;

  logic [TOT_W-1:0] total;
  logic [TOT_W-1:0] cnt_q, cnt_d;
  logic             done_q, under_q, under_d, under_set;

  assign total     = TOT_W'(ll) * TOT_W'(nn);
  assign swath_end = accept && (cnt_q == total - TOT_W'(1));
  assign under_set = wait_bank && out_ready && !out_full;

  // next-state process
  always_comb begin
    cnt_d = cnt_q;
    if (load)        cnt_d = '0;
    else if (accept) cnt_d = cnt_q + TOT_W'(1);
    under_d = under_set || (under_q && !underrun_clr);
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      done_q  <= 1'b0;
      under_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      done_q  <= swath_end;
      under_q <= under_d;
    end
  end

  assign done     = done_q;
  assign underrun = under_q;

endmodule

// File: rtl/brp_engine.sv
module brp_engine #(
  parameter int DATA_W  = 16,
  parameter int BYTE_W  = 8,
  parameter int MAX_NOZ = 64,
  parameter int LL_W    = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [LL_W-1:0]           cfg_line_len,
  input  logic [$clog2(MAX_NOZ):0]  cfg_nozzles,
  input  logic                      cfg_col_ascend,
  input  logic                      cfg_lsb_first,
  input  logic [1:0]                bank_full,
  output logic                      mem_rd_en,
  output logic [$clog2(MAX_NOZ):0]  mem_addr,
  input  logic [DATA_W-1:0]         mem_rd_data,
  output logic                      bank_done,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [BYTE_W-1:0]         out_data,
  output logic                      underrun,
  input  logic                      underrun_clr,
  output logic                      busy,
  output logic                      done
);

  localparam int NN_W  = $clog2(MAX_NOZ) + 1;
  localparam int COL_W = $clog2(DATA_W);
  localparam int BIT_W = $clog2(BYTE_W);

  logic              load, push, wait_bank, swath_end, out_full, accept;
  logic [LL_W-1:0]   ll_q;
  logic [NN_W-1:0]   nn_q;
  logic [BIT_W-1:0]  rd_pos;
  logic [COL_W-1:0]  rd_col;

  brp_walker #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W), .MAX_NOZ(MAX_NOZ), .LL_W(LL_W)
  ) u_walker (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_ll(cfg_line_len), .cfg_nn(cfg_nozzles),
    .cfg_asc(cfg_col_ascend), .cfg_lsb(cfg_lsb_first),
    .bank_full(bank_full), .out_full(out_full), .swath_end(swath_end),
    .load(load), .ll_q(ll_q), .nn_q(nn_q),
    .rd_en(mem_rd_en), .rd_addr(mem_addr), .rd_pos(rd_pos), .rd_col(rd_col),
    .push(push), .bank_done(bank_done), .wait_bank(wait_bank), .busy(busy)
  );

  brp_assembler #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_asm (
    .clk(clk), .rst_n(rst_n),
    .rd_en(mem_rd_en), .rd_pos(rd_pos), .rd_col(rd_col), .rd_data(mem_rd_data),
    .push(push), .hold(underrun), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_full(out_full),
    .accept(accept)
  );

  brp_swath_ctl #(.LL_W(LL_W), .NN_W(NN_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .load(load), .ll(ll_q), .nn(nn_q),
    .accept(accept), .wait_bank(wait_bank), .out_ready(out_ready),
    .out_full(out_full), .underrun_clr(underrun_clr),
    .swath_end(swath_end), .done(done), .underrun(underrun)
  );

endmodule

// File: rtl/brp_engine_chk.sv
module brp_engine_chk #(
  parameter int MAX_NOZ = 64,
  parameter int BYTE_W  = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     mem_rd_en,
  input logic [$clog2(MAX_NOZ):0] mem_addr,
  input logic [1:0]               bank_full,
  input logic                     bank_done,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic [BYTE_W-1:0]        out_data,
  input logic                     underrun,
  input logic                     underrun_clr,
  input logic                     busy,
  input logic                     done
);

  localparam int BANK_BIT = $clog2(MAX_NOZ);

  // R5
  no_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> bank_full[mem_addr[BANK_BIT]]);

  // R5
  bank_done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_done |-> !mem_rd_en);

  // R7
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !underrun_clr) |=> underrun);

  // R7
  underrun_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> !out_valid);

  // R8
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2
  read_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> busy);

endmodule

bind brp_engine brp_engine_chk #(.MAX_NOZ(MAX_NOZ), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
  .bank_full(bank_full), .bank_done(bank_done), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .underrun(underrun),
  .underrun_clr(underrun_clr), .busy(busy), .done(done)
);

// File: tb/brp_engine_test.sv
module brp_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam int ROW_W      = 6;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] cfg_line_len = '0;
  logic [6:0]  cfg_nozzles = '0;
  logic        cfg_col_ascend = 1'b0;
  logic        cfg_lsb_first = 1'b0;
  logic [1:0]  bank_full = 2'b00;
  logic        mem_rd_en;
  logic [6:0]  mem_addr;
  logic [15:0] mem_rd_data = '0;
  logic        bank_done, out_valid, underrun, busy, done;
  logic        out_ready = 1'b0;
  logic        underrun_clr = 1'b0;
  logic [7:0]  out_data;

  brp_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_line_len(cfg_line_len),
    .cfg_nozzles(cfg_nozzles), .cfg_col_ascend(cfg_col_ascend),
    .cfg_lsb_first(cfg_lsb_first), .bank_full(bank_full),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
    .bank_done(bank_done), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .underrun(underrun), .underrun_clr(underrun_clr),
    .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] chunk_data [16][64];
  int bank_chunk [2];
  int refill_cnt [2];
  int nchunks, dmax, cons_bank;
  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int exp_idx, bd_count, done_count, last_cyc;
  int cur_nn;
  bit cur_asc, cur_lsb;
  bit checking = 0;
  int ready_mode = 0, ready_pct = 100;
  bit auto_clr = 0, manual_clr = 0;
  bit prev_stall = 0;
  logic [7:0] prev_data = '0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(int n);
    int per, chunk, idx, ng, col, k, colbit, pos;
    logic [7:0] r;
    per = 2 * cur_nn;
    chunk = n / per;
    idx = n % per;
    ng = cur_nn / 8;
    col = idx / ng;
    k = idx % ng;
    colbit = cur_asc ? col : 15 - col;
    r = '0;
    for (int i = 0; i < 8; i++) begin
      pos = cur_lsb ? i : 7 - i;
      r[pos] = chunk_data[chunk % 16][8*k + i][colbit];
    end
    return r;
  endfunction

  // buffer model: one cycle read latency
  always @(posedge clk) begin
    if (mem_rd_en)
      mem_rd_data <= chunk_data[bank_chunk[mem_addr[ROW_W]] % 16][mem_addr[ROW_W-1:0]];
  end

  // print-side ready and flag clear, driven after the edge
  always @(posedge clk) begin
    cyc++;
    #1;
    case (ready_mode)
      0: out_ready <= (($urandom % 100) < ready_pct);
      1: out_ready <= 1'b1;
      default: out_ready <= 1'b0;
    endcase
    underrun_clr <= manual_clr || (auto_clr && underrun);
  end

  // monitors, then bank fetcher model
  always @(negedge clk) begin
    if (checking) begin
      if (mem_rd_en) begin
        // R5: never read an empty bank, and read the bank in turn
        check(bank_full[mem_addr[ROW_W]] == 1'b1, "R5", "read from empty bank", 0, 1);
        check(int'(mem_addr[ROW_W]) == cons_bank, "R5", "read bank", int'(mem_addr[ROW_W]), cons_bank);
      end
      if (prev_stall)
        // R8
        check(out_valid && out_data == prev_data, "R8", "byte held under back-pressure", int'(out_data), int'(prev_data));
      if (underrun)
        // R7
        check(!out_valid, "R7", "valid while underrun", int'(out_valid), 0);
      if (out_valid && out_ready) begin
        // R2 R3 R4: byte value and order
        check(out_data == exp_byte(exp_idx), "R2 R3 R4", $sformatf("byte %0d", exp_idx),
              int'(out_data), int'(exp_byte(exp_idx)));
        exp_idx++;
        last_cyc = cyc;
      end
      if (done) begin
        done_count++;
        // R6
        check(!busy, "R6", "busy with done", int'(busy), 0);
        check(cyc == last_cyc + 1, "R6", "done timing", cyc, last_cyc + 1);
      end
    end
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
    if (bank_done) begin
      bd_count++;
      bank_full[cons_bank] <= 1'b0;
      bank_chunk[cons_bank] = bank_chunk[cons_bank] + 2;
      if (bank_chunk[cons_bank] < nchunks)
        refill_cnt[cons_bank] = 1 + int'($urandom % (dmax + 1));
      else
        refill_cnt[cons_bank] = -1;
      cons_bank = 1 - cons_bank;
    end
    for (int b = 0; b < 2; b++) begin
      if (refill_cnt[b] > 0) begin
        refill_cnt[b]--;
        if (refill_cnt[b] == 0) begin
          bank_full[b] <= 1'b1;
          refill_cnt[b] = -1;
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > WATCHDOG) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic setup_swath(int ll, int nn, bit asc, bit lsb, int dm, bit hold1);
    for (int c = 0; c < 16; c++)
      for (int r = 0; r < 64; r++)
        chunk_data[c][r] = 16'($urandom);
    nchunks = ll / 2;
    dmax = dm;
    cur_nn = nn;
    cur_asc = asc;
    cur_lsb = lsb;
    exp_idx = 0;
    bd_count = 0;
    done_count = 0;
    last_cyc = -10;
    @(posedge clk);
    #1;
    cons_bank = 0;
    bank_chunk[0] = 0;
    bank_chunk[1] = 1;
    refill_cnt[0] = -1;
    refill_cnt[1] = -1;
    bank_full <= {(!hold1 && nchunks > 1), 1'b1};
    cfg_line_len <= 12'(ll);
    cfg_nozzles <= 7'(nn);
    cfg_col_ascend <= asc;
    cfg_lsb_first <= lsb;
    start <= 1'b1;
    checking = 1;
    @(posedge clk);
    #1;
    start <= 1'b0;
  endtask

  task automatic finish_swath(int ll, int nn);
    int t;
    t = 0;
    while (done_count == 0 && t < 60000) begin
      @(posedge clk);
      t++;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R6
    check(exp_idx == ll * nn, "R6", "bytes delivered", exp_idx, ll * nn);
    check(done_count == 1, "R6", "done pulses", done_count, 1);
    check(!busy, "R6", "busy after swath", int'(busy), 0);
    // R5
    check(bd_count == ll / 2, "R5", "bank_done pulses", bd_count, ll / 2);
    checking = 0;
  endtask

  task automatic run_swath(int ll, int nn, bit asc, bit lsb, int dm, bit restart);
    setup_swath(ll, nn, asc, lsb, dm, 1'b0);
    if (restart) begin
      repeat (40) @(posedge clk);
      #1;
      cfg_line_len <= 12'd2;
      cfg_nozzles <= 7'd8;
      cfg_col_ascend <= ~asc;
      cfg_lsb_first <= ~lsb;
      start <= 1'b1;
      @(posedge clk);
      #1;
      start <= 1'b0;
    end
    finish_swath(ll, nn);
  endtask

  initial begin
    void'($urandom(32'd7731));
    bank_chunk[0] = 0;
    bank_chunk[1] = 1;
    refill_cnt[0] = -1;
    refill_cnt[1] = -1;
    nchunks = 0;
    dmax = 0;
    cons_bank = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state during reset
    check(!out_valid && !mem_rd_en && !busy && !done && !underrun && !bank_done,
          "R1", "outputs in reset", int'({out_valid, mem_rd_en, busy, done, underrun, bank_done}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: state after release
    check(!out_valid && !mem_rd_en && !busy && !done && !underrun,
          "R1", "outputs after reset", int'({out_valid, mem_rd_en, busy, done, underrun}), 0);

    // directed corners
    auto_clr = 1;
    ready_mode = 1;
    run_swath(2, 8, 1'b0, 1'b0, 0, 1'b0);    // R2 R3 smallest swath
    run_swath(2, 64, 1'b1, 1'b0, 0, 1'b0);   // R3 ascending, most nozzles
    ready_mode = 0;
    ready_pct = 40;
    run_swath(4, 16, 1'b0, 1'b1, 10, 1'b0);  // R4 under back-pressure
    run_swath(4, 24, 1'b1, 1'b1, 5, 1'b1);   // R9 restart ignored

    // R7: underrun held while bank 1 stays empty
    auto_clr = 0;
    ready_mode = 1;
    setup_swath(4, 8, 1'b0, 1'b0, 3, 1'b1);
    repeat (400) @(posedge clk);
    @(negedge clk);
    check(underrun == 1'b1, "R7", "underrun raised", int'(underrun), 1);
    check(exp_idx == 16, "R7", "bytes before stall", exp_idx, 16);
    @(posedge clk);
    #1;
    bank_full[1] <= 1'b1;
    repeat (40) @(posedge clk);
    @(negedge clk);
    check(underrun == 1'b1, "R7", "underrun sticky after refill", int'(underrun), 1);
    check(!out_valid && exp_idx == 16, "R7", "no delivery while flagged", exp_idx, 16);
    @(posedge clk);
    #1;
    manual_clr = 1;
    @(posedge clk);
    #1;
    manual_clr = 0;
    auto_clr = 1;
    repeat (2) @(negedge clk);
    check(underrun == 1'b0, "R7", "underrun cleared", int'(underrun), 0);
    finish_swath(4, 8);

    // random swaths
    for (int s = 0; s < 6; s++) begin
      ready_mode = 0;
      ready_pct = 50 + int'($urandom % 51);
      run_swath(2 * (1 + int'($urandom % 3)), 8 * (1 + int'($urandom % 8)),
                1'($urandom), 1'($urandom), int'($urandom % 40), 1'b0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule